// File: doc/BRIEF.md
# Time-of-Day Counter with Strobe Load/Save and Rate Trim

This block keeps a free-running time of day as a 48-bit seconds count and a 30-bit nanoseconds count that wraps at one billion. Each clock cycle the nanoseconds advance by a fixed base step, eight by default. Software sets up the block through a small register write port with a combinational read port.

Software reaches the live time through one external strobe pin. The pin passes through a two-stage synchronizer, and then a rising edge does either or both of two things, depending on two enable bits. It can copy the live time into a set of captured registers, and it can replace the live time with a staged value. Two further controls correct the time. An offset register moves the time once by up to one second less one nanosecond, in either direction, with carries and borrows into the seconds. A rate trim stretches or shrinks one cycle's step by one nanosecond each time a programmable interval of nanoseconds has elapsed. A new trim setting is staged first and takes effect only when an update bit is written.

Top module: `tod_timekeeper`

## Requirements
- R1: After reset the live time, the captured time, every staged value and every control bit are zero.
- R2: With no load, offset or trim, each clock edge adds 8 ns. A nanoseconds value that reaches 1,000,000,000 or more is reduced by one billion and the seconds are incremented, so nanoseconds always stay below one billion.
- R3: Register map, using 32-bit data. Address 0 is control: bit0 enables save, bit1 enables load, bit2 is the trim update. Addresses 1, 2 and 3 are the staged seconds upper 16 bits, the staged seconds lower 32 bits and the staged nanoseconds in [29:0]. Addresses 4, 5 and 6 are the captured time in the same layout and are read-only. Address 7 is the trim: [29:0] is the interval N and bit31 is the direction, 1 to add. Address 8 is the offset: [29:0] is the magnitude, bit30 is 1 to add and bit31 is apply. Bits outside a field read as zero.
- R4: With the save enable set, the third clock edge after the pin rises copies the live time into the captured registers. The value copied is the one held just before that edge. The captured registers change at no other time.
- R5: With the load enable set, the same edge replaces the live time with the staged seconds and nanoseconds. A staged nanoseconds value above 999,999,999 is loaded as 999,999,999.
- R6: A pin rise has no effect on the captured registers or the live time while the matching enable bit is clear.
- R7: Writing the offset register with apply set changes the time at the next edge by the signed magnitude, on top of that edge's normal step. Nanoseconds wrap into the seconds, twice if needed, and a negative result borrows one second.
- R8: An offset with a magnitude of one billion or more is ignored.
- R9: Writes to the trim register have no effect until bit2 of control is written as 1. The setting then takes effect at the next edge, the interval count restarts, and bit2 reads back as 0 from then on.
- R10: With an active interval N, the step becomes 9 ns (add) or 7 ns (subtract) for one cycle each time N nanoseconds of base steps have accumulated. N=0 disables the trim. N below 8 acts as 8 and N above one billion acts as one billion.
- R11: The seconds count wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ls_pin | input | 1 | Asynchronous load/save strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds |

## Verification
The hardest case to reach from the ports is the rate trim. Its effect is spread thin over many cycles, and its phase depends on when the update was applied, so a single sample cannot show a missing or misplaced one-nanosecond step. The bench chooses each measurement window as a whole number of trim periods. The accumulator then returns to the same state at the end of the window, and the time elapsed across the window must be exactly the number of base steps plus or minus a known count. It sweeps intervals that divide the base step, intervals that do not, the clamped lower limit and the disabled setting. Offsets are swept from two starting points, one just below a second boundary and one just above. This reaches the single wrap, the double wrap and the borrow.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int unsigned NS_PER_SEC = 32'd1_000_000_000;
    localparam int REG_ADDR_W = 4;
    localparam int REG_DATA_W = 32;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_CTRL      = 4'h0,
        RA_LD_SEC_HI = 4'h1,
        RA_LD_SEC_LO = 4'h2,
        RA_LD_NS     = 4'h3,
        RA_SV_SEC_HI = 4'h4,
        RA_SV_SEC_LO = 4'h5,
        RA_SV_NS     = 4'h6,
        RA_TRIM      = 4'h7,
        RA_OFFSET    = 4'h8
    } tod_reg_e;

    localparam int CTRL_SAVE_BIT = 0;
    localparam int CTRL_LOAD_BIT = 1;
    localparam int CTRL_TRIM_BIT = 2;
    localparam int TRIM_DIR_BIT  = 31;
    localparam int OFF_ADD_BIT   = 30;
    localparam int OFF_GO_BIT    = 31;
endpackage

// File: rtl/tod_edge_sync.sv
module tod_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t             sync_q, sync_d;
    logic [STAGES-1:0] shifted;

    generate
        if (STAGES == 1) begin : g_single
            assign shifted = pin_i;
        end else begin : g_chain
            assign shifted = {sync_q.chain[STAGES-2:0], pin_i};
        end
    endgenerate

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = shifted;
        sync_d.last  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.chain[STAGES-1] & ~sync_q.last;
endmodule

// File: rtl/tod_reg_bank.sv
module tod_reg_bank
    import tod_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W  = 30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [REG_DATA_W-1:0] wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [REG_DATA_W-1:0] rd_data,
    input  logic [SEC_W-1:0]      saved_sec_i,
    input  logic [NS_W-1:0]       saved_ns_i,
    output logic                  save_en_o,
    output logic                  load_en_o,
    output logic [SEC_W-1:0]      ld_sec_o,
    output logic [NS_W-1:0]       ld_ns_o,
    output logic [NS_W-1:0]       trim_n_o,
    output logic                  trim_add_o,
    output logic                  trim_go_o,
    output logic [NS_W-1:0]       off_mag_o,
    output logic                  off_add_o,
    output logic                  off_go_o
);
    localparam int HI_W = SEC_W - REG_DATA_W;

    typedef struct packed {
        logic             save_en;
        logic             load_en;
        logic             trim_go;
        logic [SEC_W-1:0] ld_sec;
        logic [NS_W-1:0]  ld_ns;
        logic [NS_W-1:0]  trim_n;
        logic             trim_add;
        logic [NS_W-1:0]  off_mag;
        logic             off_add;
        logic             off_go;
    } bank_t;

    bank_t bank_q, bank_d;

    always_comb begin
        bank_d         = bank_q;
        bank_d.trim_go = 1'b0;
        bank_d.off_go  = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                RA_CTRL: begin
                    bank_d.save_en = wr_data[CTRL_SAVE_BIT];
                    bank_d.load_en = wr_data[CTRL_LOAD_BIT];
                    bank_d.trim_go = wr_data[CTRL_TRIM_BIT];
                end
                RA_LD_SEC_HI: bank_d.ld_sec[SEC_W-1:REG_DATA_W] = wr_data[HI_W-1:0];
                RA_LD_SEC_LO: bank_d.ld_sec[REG_DATA_W-1:0]     = wr_data;
                RA_LD_NS:     bank_d.ld_ns                      = wr_data[NS_W-1:0];
                RA_TRIM: begin
                    bank_d.trim_n   = wr_data[NS_W-1:0];
                    bank_d.trim_add = wr_data[TRIM_DIR_BIT];
                end
                RA_OFFSET: begin
                    bank_d.off_mag = wr_data[NS_W-1:0];
                    bank_d.off_add = wr_data[OFF_ADD_BIT];
                    bank_d.off_go  = wr_data[OFF_GO_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL: begin
                rd_data[CTRL_SAVE_BIT] = bank_q.save_en;
                rd_data[CTRL_LOAD_BIT] = bank_q.load_en;
                rd_data[CTRL_TRIM_BIT] = bank_q.trim_go;
            end
            RA_LD_SEC_HI: rd_data[HI_W-1:0] = bank_q.ld_sec[SEC_W-1:REG_DATA_W];
            RA_LD_SEC_LO: rd_data           = bank_q.ld_sec[REG_DATA_W-1:0];
            RA_LD_NS:     rd_data[NS_W-1:0] = bank_q.ld_ns;
            RA_SV_SEC_HI: rd_data[HI_W-1:0] = saved_sec_i[SEC_W-1:REG_DATA_W];
            RA_SV_SEC_LO: rd_data           = saved_sec_i[REG_DATA_W-1:0];
            RA_SV_NS:     rd_data[NS_W-1:0] = saved_ns_i;
            RA_TRIM: begin
                rd_data[NS_W-1:0]    = bank_q.trim_n;
                rd_data[TRIM_DIR_BIT] = bank_q.trim_add;
            end
            RA_OFFSET: begin
                rd_data[NS_W-1:0]   = bank_q.off_mag;
                rd_data[OFF_ADD_BIT] = bank_q.off_add;
                rd_data[OFF_GO_BIT]  = bank_q.off_go;
            end
            default: ;
        endcase
    end

    assign save_en_o  = bank_q.save_en;
    assign load_en_o  = bank_q.load_en;
    assign ld_sec_o   = bank_q.ld_sec;
    assign ld_ns_o    = bank_q.ld_ns;
    assign trim_n_o   = bank_q.trim_n;
    assign trim_add_o = bank_q.trim_add;
    assign trim_go_o  = bank_q.trim_go;
    assign off_mag_o  = bank_q.off_mag;
    assign off_add_o  = bank_q.off_add;
    assign off_go_o   = bank_q.off_go;
endmodule

// File: rtl/tod_rate_trim.sv
module tod_rate_trim
    import tod_pkg::*;
#(
    parameter int BASE_INC = 8,
    parameter int NS_W     = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            apply_i,
    input  logic [NS_W-1:0] cfg_n_i,
    input  logic            cfg_add_i,
    output logic            fire_o,
    output logic            add_o
);
    localparam int              ACC_W = NS_W + 1;
    localparam logic [NS_W-1:0] N_MIN = NS_W'(BASE_INC);
    localparam logic [NS_W-1:0] N_MAX = NS_W'(NS_PER_SEC);

    typedef struct packed {
        logic [NS_W-1:0]  n;
        logic             add;
        logic [ACC_W-1:0] acc;
    } trim_t;

    trim_t            trim_q, trim_d;
    logic [NS_W-1:0]  n_eff;
    logic [ACC_W-1:0] acc_sum;
    logic             fire;

    always_comb begin
        n_eff = trim_q.n;
        if (trim_q.n < N_MIN)      n_eff = N_MIN;
        else if (trim_q.n > N_MAX) n_eff = N_MAX;

        acc_sum = trim_q.acc + ACC_W'(BASE_INC);
        fire    = (trim_q.n != '0) && (acc_sum >= {1'b0, n_eff});

        trim_d = trim_q;
        if (trim_q.n != '0) begin
            trim_d.acc = fire ? (acc_sum - {1'b0, n_eff}) : acc_sum;
        end
        if (apply_i) begin
            trim_d.n   = cfg_n_i;
            trim_d.add = cfg_add_i;
            trim_d.acc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trim_q <= '0;
        else        trim_q <= trim_d;
    end

    assign fire_o = fire;
    assign add_o  = trim_q.add;
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
    import tod_pkg::*;
#(
    parameter int BASE_INC = 8,
    parameter int SEC_W    = 48,
    parameter int NS_W     = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_hit_i,
    input  logic             load_hit_i,
    input  logic [SEC_W-1:0] ld_sec_i,
    input  logic [NS_W-1:0]  ld_ns_i,
    input  logic             trim_fire_i,
    input  logic             trim_add_i,
    input  logic             off_go_i,
    input  logic [NS_W-1:0]  off_mag_i,
    input  logic             off_add_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [NS_W-1:0]  ns_o,
    output logic [SEC_W-1:0] saved_sec_o,
    output logic [NS_W-1:0]  saved_ns_o
);
    localparam int SUM_W = NS_W + 4;
    typedef logic signed [SUM_W-1:0] sum_t;

    localparam sum_t            ONE_SEC = sum_t'(NS_PER_SEC);
    localparam sum_t            TWO_SEC = ONE_SEC + ONE_SEC;
    localparam sum_t            BASE_S  = sum_t'(BASE_INC);
    localparam logic [NS_W-1:0] NS_LIM  = NS_W'(NS_PER_SEC);
    localparam logic [NS_W-1:0] NS_MAX  = NS_W'(NS_PER_SEC - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [SEC_W-1:0] sv_sec;
        logic [NS_W-1:0]  sv_ns;
    } time_t;

    time_t time_q, time_d;
    sum_t  step, shift, total;

    function automatic sum_t widen(input logic [NS_W-1:0] v);
        return $signed({{(SUM_W-NS_W){1'b0}}, v});
    endfunction

    always_comb begin
        time_d = time_q;

        step = BASE_S;
        if (trim_fire_i) step = trim_add_i ? (BASE_S + sum_t'(1)) : (BASE_S - sum_t'(1));

        shift = '0;
        if (off_go_i && (off_mag_i < NS_LIM)) begin
            shift = off_add_i ? widen(off_mag_i) : -widen(off_mag_i);
        end

        total = widen(time_q.ns) + step + shift;
        if (total < sum_t'(0)) begin
            total      = total + ONE_SEC;
            time_d.sec = time_q.sec - SEC_W'(1);
        end else if (total >= TWO_SEC) begin
            total      = total - TWO_SEC;
            time_d.sec = time_q.sec + SEC_W'(2);
        end else if (total >= ONE_SEC) begin
            total      = total - ONE_SEC;
            time_d.sec = time_q.sec + SEC_W'(1);
        end
        time_d.ns = total[NS_W-1:0];

        if (load_hit_i) begin
            time_d.sec = ld_sec_i;
            time_d.ns  = (ld_ns_i > NS_MAX) ? NS_MAX : ld_ns_i;
        end

        if (save_hit_i) begin
            time_d.sv_sec = time_q.sec;
            time_d.sv_ns  = time_q.ns;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_d;
    end

    assign sec_o       = time_q.sec;
    assign ns_o        = time_q.ns;
    assign saved_sec_o = time_q.sv_sec;
    assign saved_ns_o  = time_q.sv_ns;
endmodule

// File: rtl/tod_timekeeper.sv
module tod_timekeeper
    import tod_pkg::*;
#(
    parameter int BASE_INC    = 8,
    parameter int SEC_W       = 48,
    parameter int NS_W        = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ls_pin,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [REG_DATA_W-1:0] wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [REG_DATA_W-1:0] rd_data,
    output logic [SEC_W-1:0]      tod_sec,
    output logic [NS_W-1:0]       tod_ns
);
    logic             ls_rise, save_en, load_en, save_hit, load_hit;
    logic [SEC_W-1:0] ld_sec, saved_sec;
    logic [NS_W-1:0]  ld_ns, saved_ns, trim_n, off_mag;
    logic             trim_cfg_add, trim_go, off_add, off_go;
    logic             trim_fire, trim_add;

    tod_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ls_pin),
        .rise_o (ls_rise)
    );

    tod_reg_bank #(.SEC_W(SEC_W), .NS_W(NS_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .saved_sec_i (saved_sec),
        .saved_ns_i  (saved_ns),
        .save_en_o   (save_en),
        .load_en_o   (load_en),
        .ld_sec_o    (ld_sec),
        .ld_ns_o     (ld_ns),
        .trim_n_o    (trim_n),
        .trim_add_o  (trim_cfg_add),
        .trim_go_o   (trim_go),
        .off_mag_o   (off_mag),
        .off_add_o   (off_add),
        .off_go_o    (off_go)
    );

    tod_rate_trim #(.BASE_INC(BASE_INC), .NS_W(NS_W)) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply_i   (trim_go),
        .cfg_n_i   (trim_n),
        .cfg_add_i (trim_cfg_add),
        .fire_o    (trim_fire),
        .add_o     (trim_add)
    );

    assign save_hit = ls_rise & save_en;
    assign load_hit = ls_rise & load_en;

    tod_time_core #(.BASE_INC(BASE_INC), .SEC_W(SEC_W), .NS_W(NS_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_hit_i  (save_hit),
        .load_hit_i  (load_hit),
        .ld_sec_i    (ld_sec),
        .ld_ns_i     (ld_ns),
        .trim_fire_i (trim_fire),
        .trim_add_i  (trim_add),
        .off_go_i    (off_go),
        .off_mag_i   (off_mag),
        .off_add_i   (off_add),
        .sec_o       (tod_sec),
        .ns_o        (tod_ns),
        .saved_sec_o (saved_sec),
        .saved_ns_o  (saved_ns)
    );
endmodule

// File: rtl/tod_timekeeper_chk.sv
module tod_timekeeper_chk
    import tod_pkg::*;
#(
    parameter int BASE_INC = 8,
    parameter int SEC_W    = 48,
    parameter int NS_W     = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             ls_rise,
    input logic             save_hit,
    input logic             load_hit,
    input logic             off_go,
    input logic             trim_fire,
    input logic             trim_go,
    input logic [NS_W-1:0]  tod_ns,
    input logic [SEC_W-1:0] saved_sec,
    input logic [NS_W-1:0]  saved_ns
);
    localparam logic [NS_W:0] LIM_W  = (NS_W+1)'(NS_PER_SEC);
    localparam logic [NS_W:0] STEP_W = (NS_W+1)'(BASE_INC);

    // R2: nanoseconds never reach one billion
    a_r2_ns_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, tod_ns} < LIM_W);

    // R2: an undisturbed cycle away from the wrap adds exactly the base step
    a_r2_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_hit && !off_go && !trim_fire && ({1'b0, tod_ns} + STEP_W < LIM_W))
        |=> ({1'b0, tod_ns} == {1'b0, $past(tod_ns)} + STEP_W));

    // R4: captured time only moves on a save hit
    a_r4_saved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !save_hit |=> ($stable(saved_sec) && $stable(saved_ns)));

    // R4: a save hit captures the pre-edge live nanoseconds
    a_r4_save_copy: assert property (@(posedge clk) disable iff (!rst_n)
        save_hit |=> (saved_ns == $past(tod_ns)));

    // R4: one pin rise yields a single-cycle detection pulse
    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        ls_rise |=> !ls_rise);

    // R9: the trim update bit clears after it has been applied
    a_r9_update_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_go && !wr_en) |=> !trim_go);
endmodule

bind tod_timekeeper tod_timekeeper_chk #(
    .BASE_INC (BASE_INC),
    .SEC_W    (SEC_W),
    .NS_W     (NS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .ls_rise   (ls_rise),
    .save_hit  (save_hit),
    .load_hit  (load_hit),
    .off_go    (off_go),
    .trim_fire (trim_fire),
    .trim_go   (trim_go),
    .tod_ns    (tod_ns),
    .saved_sec (saved_sec),
    .saved_ns  (saved_ns)
);

// File: tb/sim_tod_timekeeper.sv
module sim_tod_timekeeper;
    localparam longint BILLION = 64'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ls_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;

    int n_chk = 0;
    int n_bad = 0;
    longint pre_sec, pre_ns, at_sec, at_ns;

    always #10 clk = ~clk;

    tod_timekeeper u0 (
        .clk(clk), .rst_n(rst_n), .ls_pin(ls_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tod_sec(tod_sec), .tod_ns(tod_ns)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint tot();
        return longint'(tod_sec) * BILLION + longint'(tod_ns);
    endfunction

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // pin rise; action lands on the third edge
    task automatic pulse_pin();
        ls_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pre_sec = longint'(tod_sec); pre_ns = longint'(tod_ns);
        @(negedge clk);
        at_sec = longint'(tod_sec); at_ns = longint'(tod_ns);
        ls_pin = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_load(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] ns);
        reg_wr(4'h1, hi);
        reg_wr(4'h2, lo);
        reg_wr(4'h3, ns);
        reg_wr(4'h0, 32'h2);
        pulse_pin();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        longint v0, t0, t1, sv_s, sv_n;
        longint offs [8] = '{1, -1, 500, -500, 999_999_999, -999_999_999, 123_456_789, -7};
        int trim_n [7] = '{40, 40, 12, 24, 3, 1000, 0};
        bit trim_a [7] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(tod_sec == 0 && tod_ns == 0, "R1 live time", tot(), 0);
        reg_rd(4'h0, rv); chk(rv == 0, "R1 control", rv, 0);
        reg_rd(4'h6, rv); chk(rv == 0, "R1 captured ns", rv, 0);
        reg_rd(4'h7, rv); chk(rv == 0, "R1 trim", rv, 0);
        rst_n = 1'b1;

        // R2 base step
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            chk(tot() == 8 * i, "R2 step", tot(), 8 * i);
        end

        // R3 register readback and field widths
        reg_wr(4'h1, 32'hFFFF_1234); reg_rd(4'h1, rv); chk(rv == 32'h1234, "R3 sec hi", rv, 32'h1234);
        reg_wr(4'h2, 32'hDEAD_BEEF); reg_rd(4'h2, rv); chk(rv == 32'hDEAD_BEEF, "R3 sec lo", rv, 32'hDEAD_BEEF);
        reg_wr(4'h3, 32'hFFFF_FFFF); reg_rd(4'h3, rv); chk(rv == 32'h3FFF_FFFF, "R3 ns", rv, 32'h3FFF_FFFF);
        reg_wr(4'h8, 32'h7FFF_FFFF); reg_rd(4'h8, rv); chk(rv == 32'h7FFF_FFFF, "R3 offset", rv, 32'h7FFF_FFFF);
        reg_rd(4'h9, rv); chk(rv == 0, "R3 unused addr", rv, 0);

        // R5 load and R2 wrap
        do_load(32'h0, 32'd5, 32'd999_999_990);
        chk(at_sec == 5 && at_ns == 999_999_990, "R5 load", at_sec * BILLION + at_ns, 5 * BILLION + 999_999_990);
        chk(tod_sec == 6 && tod_ns == 14, "R2 wrap", tot(), 6 * BILLION + 14);
        do_load(32'h0, 32'd7, 32'h3FFF_FFFF);
        chk(at_sec == 7 && at_ns == 999_999_999, "R5 clamp", at_sec * BILLION + at_ns, 7 * BILLION + 999_999_999);

        // R11 seconds wrap
        do_load(32'hFFFF, 32'hFFFF_FFFF, 32'd999_999_995);
        chk(tod_sec == 0 && tod_ns == 19, "R11 seconds wrap", tot(), 19);

        // R4 save with load disabled
        do_load(32'h0, 32'd3, 32'd100);
        reg_wr(4'h0, 32'h1);
        reg_wr(4'h1, 32'h0); reg_wr(4'h2, 32'd77); reg_wr(4'h3, 32'd0);
        pulse_pin();
        reg_rd(4'h5, rv); sv_s = longint'(rv);
        reg_rd(4'h6, rv); sv_n = longint'(rv);
        chk(sv_s * BILLION + sv_n == pre_sec * BILLION + pre_ns, "R4 saved time",
            sv_s * BILLION + sv_n, pre_sec * BILLION + pre_ns);
        reg_rd(4'h4, rv); chk(rv == 0, "R4 saved sec hi", rv, 0);
        chk(tot() == pre_sec * BILLION + pre_ns + 32, "R6 no load while disabled",
            tot(), pre_sec * BILLION + pre_ns + 32);

        // R6 both enables clear
        reg_wr(4'h0, 32'h0);
        pulse_pin();
        reg_rd(4'h6, rv); chk(longint'(rv) == sv_n, "R6 saved unchanged", rv, sv_n);
        chk(tot() == pre_sec * BILLION + pre_ns + 32, "R6 live unchanged",
            tot(), pre_sec * BILLION + pre_ns + 32);

        // R7 offset sweep from two starting points
        for (int p = 0; p < 2; p++) begin
            do_load(32'h0, 32'd10, (p == 0) ? 32'd999_999_000 : 32'd50);
            reg_wr(4'h0, 32'h0);
            for (int k = 0; k < 8; k++) begin
                longint m;
                m = (offs[k] < 0) ? -offs[k] : offs[k];
                v0 = tot();
                reg_wr(4'h8, 32'h8000_0000 | ((offs[k] > 0) ? 32'h4000_0000 : 32'h0) | 32'(m));
                @(negedge clk);
                chk(tot() == v0 + 16 + offs[k], "R7 offset", tot(), v0 + 16 + offs[k]);
            end
        end

        // R8 oversize offsets ignored
        v0 = tot();
        reg_wr(4'h8, 32'hC000_0000 | 32'd1_000_000_000);
        @(negedge clk);
        chk(tot() == v0 + 16, "R8 offset at one second", tot(), v0 + 16);
        v0 = tot();
        reg_wr(4'h8, 32'hBFFF_FFFF);
        @(negedge clk);
        chk(tot() == v0 + 16, "R8 offset max field", tot(), v0 + 16);

        // R9 staged trim has no effect before update
        reg_wr(4'h7, 32'h8000_0000 | 32'd40);
        repeat (5) @(negedge clk);
        t0 = tot(); repeat (100) @(negedge clk); t1 = tot();
        chk(t1 - t0 == 800, "R9 staged only", t1 - t0, 800);

        // R10 trim sweep, windows of whole periods
        for (int k = 0; k < 7; k++) begin
            longint neff, m, fires, expd;
            neff = (trim_n[k] < 8) ? 8 : trim_n[k];
            m = (trim_n[k] == 0) ? 100 : 5 * neff;
            fires = (trim_n[k] == 0) ? 0 : (m * 8) / neff;
            expd = m * 8 + (trim_a[k] ? fires : -fires);
            reg_wr(4'h7, (trim_a[k] ? 32'h8000_0000 : 32'h0) | 32'(trim_n[k]));
            reg_wr(4'h0, 32'h4);
            @(negedge clk);
            reg_rd(4'h0, rv); chk(rv[2] == 1'b0, "R9 update clears", rv, 0);
            repeat (10) @(negedge clk);
            t0 = tot(); repeat (int'(m)) @(negedge clk); t1 = tot();
            chk(t1 - t0 == expd, "R10 trim window", t1 - t0, expd);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule